// File: doc/BRIEF.md
# Handshaked Device Port Controller

This block sits on the device side of a host register bus. The host sees four byte-wide registers: status, command/control, data-in and data-out. It sends one byte at a time to a device. To do that, it loads the data-out register and then sets a command-ready bit together with a write bit. The controller raises busy on the next clock and offers the byte on a valid/ready output towards the device. When the device accepts the byte, the controller drops command-ready and busy together. In the same cycle it either clears the error bit (clean transfer) or sets it (the device reported a failure).

The same command register carries the line mode: a duplex select, a parity enable, a 7/8-bit length select and a three-bit speed code. These bits drive the device side directly as configuration outputs. In the other direction, the device can deliver bytes into data-in at any time. Each delivery sets a byte-available flag, and a host read of data-in clears that flag. A delivery that lands while the flag is still set marks an overrun.

The host bus is single-cycle. Writes are taken on the clock edge. Read data is combinational from the address while the read strobe is high. Reading data-in is the only read that changes state.

Top module: `devport_ctrl`

## Requirements
- R1: After reset the status and command registers read 0, data-in reads 0, the device output valid is low and all configuration outputs are 0.
- R2: Register offsets are status=0, command=1, data-in=2, data-out=3. Data-out is write-only and reads as 0. Status bits are bit0 busy, bit1 byte-available, bit2 error and bit3 overrun, with bits 7:4 reading 0.
- R3: When command-ready (command bit0) is set while busy is clear, busy reads 1 from the next clock on.
- R4: For a command with the write bit (command bit1) set, the device output valid is high only while busy. It carries the data-out byte and stays high with unchanged data until the device asserts ready.
- R5: In the cycle the device accepts the byte without failure, command-ready, busy and error all clear together. The other command bits keep their value.
- R6: When the device signals failure together with ready, error is set, and command-ready and busy still clear in that same cycle.
- R7: A command whose write bit is clear completes one cycle after busy rises, with error set and without ever raising the device output valid.
- R8: While busy is set, host writes to data-out and to the command register have no effect.
- R9: The configuration outputs follow the command register: duplex = bit2, parity enable = bit3, 8-bit length = bit4, speed = bits 7:5.
- R10: A device delivery loads data-in and sets byte-available. A host read of data-in returns the stored byte and clears byte-available and overrun.
- R11: A delivery while byte-available is set and no data-in read is taking place sets overrun and replaces the stored byte. A delivery in the same cycle as a data-in read leaves byte-available set and overrun clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Register offset |
| host_wr | input | 1 | Write strobe, taken on the clock edge |
| host_rd | input | 1 | Read strobe; a data-in read consumes the byte |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational, 0 when no read |
| dev_tx_valid | output | 1 | Byte offered to the device |
| dev_tx_data | output | 8 | Byte offered to the device |
| dev_tx_ready | input | 1 | Device accepts the offered byte |
| dev_tx_fail | input | 1 | Device reports failure, sampled with ready |
| dev_rx_valid | input | 1 | Device delivers a byte into data-in |
| dev_rx_data | input | 8 | Delivered byte |
| cfg_full_duplex | output | 1 | Duplex select |
| cfg_parity_en | output | 1 | Parity enable |
| cfg_len8 | output | 1 | 1 = 8-bit words, 0 = 7-bit words |
| cfg_speed | output | 3 | Speed code |

## Verification
The properties assume that the device asserts ready only while valid is high, and that failure has meaning only together with ready. The bench's device model raises ready exactly once per offered byte, after a random delay, and drives failure low at every other time. The properties also assume that host strobes are held for exactly one clock. Every bench access is a one-cycle pulse set up on the falling edge. Device deliveries are one-cycle pulses that come at random points relative to host reads, and one of them is deliberately placed in the same cycle as a data-in read.

// File: rtl/devport_pkg.sv
package devport_pkg;

    typedef enum logic [1:0] {
        REG_STAT = 2'd0,
        REG_CTRL = 2'd1,
        REG_DIN  = 2'd2,
        REG_DOUT = 2'd3
    } reg_sel_e;

    // command register bit positions
    localparam int unsigned CB_GO   = 0;
    localparam int unsigned CB_WR   = 1;
    localparam int unsigned CB_DUP  = 2;
    localparam int unsigned CB_PAR  = 3;
    localparam int unsigned CB_LEN8 = 4;
    localparam int unsigned CB_SPD  = 5;

    // status register bit positions
    localparam int unsigned SB_BUSY  = 0;
    localparam int unsigned SB_AVAIL = 1;
    localparam int unsigned SB_ERR   = 2;
    localparam int unsigned SB_OVR   = 3;

    typedef enum logic [0:0] {
        XS_IDLE = 1'b0,
        XS_EXEC = 1'b1
    } xfer_state_e;

endpackage

// File: rtl/devport_hostregs.sv
module devport_hostregs
    import devport_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              busy,
    input  logic              done,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] dout_o
);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] dout;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (host_wr && !busy) begin
            case (reg_sel_e'(host_addr))
                REG_CTRL: st_d.ctrl = host_wdata;
                REG_DOUT: st_d.dout = host_wdata;
                default:  ;
            endcase
        end
        if (done) begin
            st_d.ctrl[CB_GO] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;
    assign dout_o = st_q.dout;

endmodule

// File: rtl/devport_xfer.sv
module devport_xfer
    import devport_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              wr_cmd,
    input  logic [DATA_W-1:0] dout,
    input  logic              tx_ready,
    input  logic              tx_fail,
    output logic              busy_o,
    output logic              err_o,
    output logic              done_o,
    output logic              tx_valid_o,
    output logic [DATA_W-1:0] tx_data_o
);

    typedef struct packed {
        xfer_state_e state;
        logic        err;
    } xfer_t;

    xfer_t st_d, st_q;
    logic  done_d;

    always_comb begin
        st_d   = st_q;
        done_d = 1'b0;
        case (st_q.state)
            XS_IDLE: begin
                if (go) begin
                    st_d.state = XS_EXEC;
                end
            end
            XS_EXEC: begin
                if (!wr_cmd) begin
                    done_d     = 1'b1;
                    st_d.err   = 1'b1;
                    st_d.state = XS_IDLE;
                end else if (tx_ready) begin
                    done_d     = 1'b1;
                    st_d.err   = tx_fail;
                    st_d.state = XS_IDLE;
                end
            end
            default: st_d.state = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: XS_IDLE, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o     = (st_q.state == XS_EXEC);
    assign err_o      = st_q.err;
    assign done_o     = done_d;
    assign tx_valid_o = (st_q.state == XS_EXEC) && wr_cmd;
    assign tx_data_o  = dout;

endmodule

// File: rtl/devport_rxcap.sv
module devport_rxcap #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              take,
    output logic [DATA_W-1:0] din_o,
    output logic              avail_o,
    output logic              ovr_o
);

    typedef struct packed {
        logic [DATA_W-1:0] din;
        logic              avail;
        logic              ovr;
    } rx_t;

    rx_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.avail = 1'b0;
            st_d.ovr   = 1'b0;
        end
        if (rx_valid) begin
            st_d.din   = rx_data;
            st_d.avail = 1'b1;
            if (st_q.avail && !take) begin
                st_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign din_o   = st_q.din;
    assign avail_o = st_q.avail;
    assign ovr_o   = st_q.ovr;

endmodule

// File: rtl/devport_ctrl.sv
module devport_ctrl
    import devport_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    localparam int unsigned SPEED_W = DATA_W - CB_SPD
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               dev_tx_valid,
    output logic [DATA_W-1:0]  dev_tx_data,
    input  logic               dev_tx_ready,
    input  logic               dev_tx_fail,
    input  logic               dev_rx_valid,
    input  logic [DATA_W-1:0]  dev_rx_data,
    output logic               cfg_full_duplex,
    output logic               cfg_parity_en,
    output logic               cfg_len8,
    output logic [SPEED_W-1:0] cfg_speed
);

    logic [DATA_W-1:0] ctrl_w;
    logic [DATA_W-1:0] dout_w;
    logic [DATA_W-1:0] din_w;
    logic              busy_w;
    logic              err_w;
    logic              done_w;
    logic              avail_w;
    logic              ovr_w;
    logic              take_w;
    logic [DATA_W-1:0] stat_w;

    devport_hostregs #(.DATA_W(DATA_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .busy       (busy_w),
        .done       (done_w),
        .ctrl_o     (ctrl_w),
        .dout_o     (dout_w)
    );

    devport_xfer #(.DATA_W(DATA_W)) xfer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (ctrl_w[CB_GO]),
        .wr_cmd     (ctrl_w[CB_WR]),
        .dout       (dout_w),
        .tx_ready   (dev_tx_ready),
        .tx_fail    (dev_tx_fail),
        .busy_o     (busy_w),
        .err_o      (err_w),
        .done_o     (done_w),
        .tx_valid_o (dev_tx_valid),
        .tx_data_o  (dev_tx_data)
    );

    assign take_w = host_rd && (reg_sel_e'(host_addr) == REG_DIN);

    devport_rxcap #(.DATA_W(DATA_W)) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (dev_rx_valid),
        .rx_data  (dev_rx_data),
        .take     (take_w),
        .din_o    (din_w),
        .avail_o  (avail_w),
        .ovr_o    (ovr_w)
    );

    always_comb begin
        stat_w           = '0;
        stat_w[SB_BUSY]  = busy_w;
        stat_w[SB_AVAIL] = avail_w;
        stat_w[SB_ERR]   = err_w;
        stat_w[SB_OVR]   = ovr_w;
    end

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            case (reg_sel_e'(host_addr))
                REG_STAT: host_rdata = stat_w;
                REG_CTRL: host_rdata = ctrl_w;
                REG_DIN:  host_rdata = din_w;
                default:  host_rdata = '0;
            endcase
        end
    end

    assign cfg_full_duplex = ctrl_w[CB_DUP];
    assign cfg_parity_en   = ctrl_w[CB_PAR];
    assign cfg_len8        = ctrl_w[CB_LEN8];
    assign cfg_speed       = ctrl_w[DATA_W-1:CB_SPD];

endmodule

// File: rtl/devport_ctrl_sva.sv
module devport_ctrl_sva #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              cmd_rdy,
    input logic              wr_bit,
    input logic              err,
    input logic              avail,
    input logic              ovr,
    input logic              take,
    input logic              rx_valid,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              tx_fail,
    input logic [DATA_W-1:0] tx_data,
    input logic [DATA_W-1:0] dout,
    input logic [DATA_W-1:0] ctrl
);

    assert_go_raises_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rdy && !busy |=> busy);

    assert_valid_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

    assert_valid_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    assert_clean_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && !tx_fail |=> !busy && !cmd_rdy && !err);

    assert_busy_drop_clears_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !cmd_rdy);

    assert_fail_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_fail |=> !busy && !cmd_rdy && err);

    assert_nowrite_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !wr_bit |=> !busy && err);

    assert_frozen_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dout) && $stable(ctrl[DATA_W-1:1]));

    assert_take_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take && !rx_valid |=> !avail && !ovr);

    assert_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && avail && !take |=> avail && ovr);

endmodule

bind devport_ctrl devport_ctrl_sva #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy_w),
    .cmd_rdy  (ctrl_w[0]),
    .wr_bit   (ctrl_w[1]),
    .err      (err_w),
    .avail    (avail_w),
    .ovr      (ovr_w),
    .take     (take_w),
    .rx_valid (dev_rx_valid),
    .tx_valid (dev_tx_valid),
    .tx_ready (dev_tx_ready),
    .tx_fail  (dev_tx_fail),
    .tx_data  (dev_tx_data),
    .dout     (dout_w),
    .ctrl     (ctrl_w)
);

// File: tb/devport_ctrl_tb_top.sv
module devport_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] host_addr;
    logic       host_wr, host_rd;
    logic [7:0] host_wdata, host_rdata;
    logic       dev_tx_valid;
    logic [7:0] dev_tx_data;
    logic       dev_tx_ready, dev_tx_fail;
    logic       dev_rx_valid;
    logic [7:0] dev_rx_data;
    logic       cfg_full_duplex, cfg_parity_en, cfg_len8;
    logic [2:0] cfg_speed;

    always #2 clk = ~clk;

    devport_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data),
        .dev_tx_ready(dev_tx_ready), .dev_tx_fail(dev_tx_fail),
        .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
        .cfg_full_duplex(cfg_full_duplex), .cfg_parity_en(cfg_parity_en),
        .cfg_len8(cfg_len8), .cfg_speed(cfg_speed)
    );

    int n_chk = 0;
    int n_bad = 0;

    // device model settings and observations
    int         dly_cfg = 0;
    bit         fail_cfg = 0;
    int         wcnt = 0;
    logic [7:0] cap = '0;
    int         ncap = 0;
    int         valid_cycles = 0;

    // bench reference state
    logic [7:0] m_dout = '0;
    logic [7:0] m_din = '0;
    bit         m_avail = 0, m_ovr = 0, m_err = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_stat(input bit busy, input bit av, input bit er, input bit ov);
        return {4'b0, ov, er, av, busy};
    endfunction

    // device side: offers accepted after dly_cfg extra cycles
    always @(negedge clk) begin
        dev_tx_ready = 1'b0;
        dev_tx_fail  = 1'b0;
        if (rst_n && dev_tx_valid) begin
            valid_cycles++;
            if (wcnt >= dly_cfg) begin
                dev_tx_ready = 1'b1;
                dev_tx_fail  = fail_cfg;
                cap  = dev_tx_data;
                ncap++;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] v);
        host_addr = a; host_rd = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic check_status(input string req);
        logic [7:0] s;
        host_read(2'd0, s);
        chk(req, s, exp_stat(0, m_avail, m_err, m_ovr));
    endtask

    task automatic do_cmd(input logic [7:0] cv, input logic [7:0] data, input bit load,
                          input bit f, input int d, input bit intrude);
        logic [7:0] v;
        logic [7:0] s;
        int n0, vc0;
        fail_cfg = f; dly_cfg = d; n0 = ncap; vc0 = valid_cycles;
        if (load) begin
            host_write(2'd3, data);
            m_dout = data;
        end
        host_write(2'd1, cv);
        chk("R9 cfg outputs", {cfg_speed, cfg_len8, cfg_parity_en, cfg_full_duplex}, cv[7:2]);
        host_read(2'd1, v);
        chk("R2 command readback", v, cv);
        if (cv[0]) begin
            host_read(2'd0, s);
            chk("R3 busy after go", s[0], 1'b1);
            if (intrude) begin
                host_write(2'd3, ~m_dout);
                host_write(2'd1, cv ^ 8'hFC);
            end
            for (int i = 0; i < 40; i++) begin
                host_read(2'd0, s);
                if (!s[0]) break;
            end
            m_err = cv[1] ? f : 1'b1;
            check_status(cv[1] ? (f ? "R6 fail status" : "R5 clean status") : "R7 nowrite status");
            host_read(2'd1, v);
            chk("R5 go cleared, mode kept", v, cv & 8'hFE);
            if (cv[1]) begin
                chk("R4 one byte offered", ncap, n0 + 1);
                chk("R4 offered byte", cap, m_dout);
            end else begin
                chk("R7 no offer", valid_cycles, vc0);
            end
            if (intrude) begin
                chk("R8 cfg unchanged", {cfg_speed, cfg_len8, cfg_parity_en, cfg_full_duplex}, cv[7:2]);
            end
        end else begin
            check_status("R9 mode-only write leaves status");
        end
    endtask

    task automatic rx_push(input logic [7:0] d);
        dev_rx_valid = 1'b1; dev_rx_data = d;
        @(negedge clk);
        dev_rx_valid = 1'b0;
        if (m_avail) m_ovr = 1;
        m_avail = 1; m_din = d;
    endtask

    task automatic rx_read();
        logic [7:0] v;
        host_read(2'd2, v);
        chk("R10 data-in value", v, m_din);
        m_avail = 0; m_ovr = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4242));
        rst_n = 1'b0; host_addr = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
        dev_rx_valid = 0; dev_rx_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 tx valid low", dev_tx_valid, 1'b0);
        chk("R1 cfg zero", {cfg_speed, cfg_len8, cfg_parity_en, cfg_full_duplex}, 6'd0);
        host_read(2'd0, v); chk("R1 status zero", v, 8'h00);
        host_read(2'd1, v); chk("R1 command zero", v, 8'h00);
        host_read(2'd2, v); chk("R1 data-in zero", v, 8'h00);

        // directed corner cases
        do_cmd(8'hB7, 8'h5A, 1, 0, 0, 0);   // clean, immediate accept
        do_cmd(8'h4B, 8'hC3, 1, 1, 3, 0);   // failure after wait
        do_cmd(8'h1F, 8'h77, 1, 0, 2, 0);   // clean clears error
        do_cmd(8'hE1, 8'h00, 0, 0, 0, 0);   // no write bit
        do_cmd(8'h6B, 8'h3C, 1, 0, 8, 1);   // writes while busy ignored
        do_cmd(8'h6B, 8'h00, 0, 0, 1, 0);   // R8 resend keeps old byte
        do_cmd(8'hA8, 8'h00, 0, 0, 0, 0);   // mode only
        host_write(2'd3, 8'h99); m_dout = 8'h99;
        host_read(2'd3, v); chk("R2 data-out reads zero", v, 8'h00);

        rx_push(8'h11);
        check_status("R10 byte available");
        rx_read();
        check_status("R10 cleared by read");
        rx_push(8'h22);
        rx_push(8'h33);
        check_status("R11 overrun set");
        rx_read();
        check_status("R11 overrun cleared by read");
        rx_push(8'h44);
        // same-cycle read and delivery
        host_addr = 2'd2; host_rd = 1'b1; dev_rx_valid = 1'b1; dev_rx_data = 8'h55;
        #1 v = host_rdata;
        chk("R11 simultaneous read value", v, 8'h44);
        @(negedge clk);
        host_rd = 1'b0; dev_rx_valid = 1'b0;
        m_din = 8'h55; m_avail = 1; m_ovr = 0;
        check_status("R11 simultaneous no overrun");
        rx_read();

        // random mix
        for (int it = 0; it < 80; it++) begin
            int op;
            op = $urandom % 4;
            if (op < 2) begin
                logic [7:0] cv;
                cv = 8'($urandom);
                cv[0] = 1'b1;
                cv[1] = ($urandom % 5) != 0;
                do_cmd(cv, 8'($urandom), ($urandom % 3) != 0, ($urandom % 4) == 0,
                       int'($urandom % 5), 0);
            end else if (op == 2) begin
                rx_push(8'($urandom));
                check_status("R11 random delivery status");
            end else if (m_avail) begin
                rx_read();
                check_status("R10 random read status");
            end else begin
                check_status("R10 random idle status");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule